// File: doc/BRIEF.md
# Calibration Pulse Output Shaper

This block converts single-cycle calibration pulse requests into an active-high pulse train on one output pin. The output rests low. Each accepted request produces one high pulse, and the block chooses that pulse's width when the pulse begins.

The width is picked from three options. When requests are sparse, the block uses a long fixed width. When the spacing between the two latest requests falls below twice that long width, the block uses half of the measured spacing. When the frequency-select input holds the fast-mode code, the block uses a very short fixed width whatever the spacing. All widths and the threshold are parameters counted in clock cycles, so they scale with the clock. A request that arrives while a pulse is high is held and is never lost. A small pending counter keeps the held requests, and they are served one after another, each separated from the next by one low cycle.

The control core is a two-state machine:
- State `ST_IDLE` drives the output low.
- State `ST_HIGH` drives the output high while a remaining-cycle counter runs down.
- Transition `T_LAUNCH` (`ST_IDLE` to `ST_HIGH`) fires when a request is present or one is pending.
- Transition `T_EXPIRE` (`ST_HIGH` to `ST_IDLE`) fires when the remaining count reaches zero.
- Otherwise the machine stays in its state: `T_WAIT` in idle, `T_HOLD` in high.

Top module: `cal_pulse_shaper`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, `pulse_o` is low.
- R2: The first request after reset has no measured spacing yet, so its pulse is `LONG_W` cycles wide. This holds when the select code is not the fast code.
- R3: When the spacing between the two latest requests is at least `2*LONG_W` cycles, the pulse is `LONG_W` cycles wide. This holds when the select code is not the fast code.
- R4: When the spacing P between the two latest requests is below `2*LONG_W` cycles, the pulse is floor(P/2) cycles wide, with a minimum of 1 cycle. This holds when the select code is not the fast code.
- R5: When `freq_sel_i` equals the fast code (default 3'b011) at pulse start, the pulse is `SHORT_W` cycles wide regardless of spacing. Every other code uses R2 to R4.
- R6: A request that arrives while `pulse_o` is high is held. Held pulses start on the clock after one low cycle, in arrival order. Up to 2^`PEND_W`-1 requests can be held.
- R7: The width is fixed when a pulse starts. Changing `freq_sel_i` during a pulse does not change that pulse's length.
- R8: A request sampled while idle with nothing pending raises `pulse_o` on the next clock edge.
- R9: Two consecutive pulses are separated by at least one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle pulse request strobe |
| freq_sel_i | input | FSEL_W | Latched frequency-select code; the fast code selects the short width |
| pulse_o | output | 1 | Active-high shaped calibration pulse |

## Verification
The checks assume that `freq_sel_i` is stable on the clock edge where a pulse starts and on the edge where the checker records the mode. They also assume that no more requests pile up than the pending counter can hold. The stimulus meets both assumptions:
- It changes the select code only together with a request, or partway through a pulse that is already running.
- It issues bursts of at most three back-to-back requests.
- In the table-driven part, it spaces requests so that each pulse ends before the next request arrives.

// File: rtl/cal_pulse_pkg.sv
package cal_pulse_pkg;

    // Control states of the shaper
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HIGH = 1'b1
    } shp_state_e;

    // Width decision source (for readability of the selector)
    typedef enum logic [1:0] {
        SRC_LONG  = 2'd0,
        SRC_HALF  = 2'd1,
        SRC_SHORT = 2'd2
    } width_src_e;

endpackage

// File: rtl/cal_interval_meter.sv
module cal_interval_meter #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    output logic [CNT_W-1:0] period_o,
    output logic             valid_o
);

    logic [CNT_W-1:0] gap_q;      // cycles since the latest request, saturating
    logic             seen_q;     // at least one request since reset
    logic [CNT_W-1:0] per_q;      // spacing measured at the latest request
    logic             per_vld_q;  // per_q holds a real spacing

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q     <= '0;
            seen_q    <= 1'b0;
            per_q     <= '0;
            per_vld_q <= 1'b0;
        end else if (req_i) begin
            gap_q     <= CNT_W'(1);
            seen_q    <= 1'b1;
            per_q     <= gap_q;
            per_vld_q <= seen_q;
        end else if (gap_q != '1) begin
            gap_q     <= gap_q + CNT_W'(1);
        end
    end

    // A request in this cycle carries the freshest spacing
    always_comb begin
        if (req_i) begin
            period_o = gap_q;
            valid_o  = seen_q;
        end else begin
            period_o = per_q;
            valid_o  = per_vld_q;
        end
    end

endmodule

// File: rtl/cal_width_select.sv
module cal_width_select
    import cal_pulse_pkg::*;
#(
    parameter int          CNT_W     = 8,
    parameter int          LONG_W    = 20,
    parameter int          SHORT_W   = 3,
    parameter int          FSEL_W    = 3,
    parameter logic [FSEL_W-1:0] FAST_CODE = FSEL_W'(3)
) (
    input  logic [CNT_W-1:0]  period_i,
    input  logic              valid_i,
    input  logic [FSEL_W-1:0] fsel_i,
    output logic [CNT_W-1:0]  width_o
);

    localparam logic [CNT_W-1:0] THR_V   = CNT_W'(2 * LONG_W);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_W);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_W);

    logic             fast_hit;
    logic [CNT_W-1:0] half_w;
    width_src_e       src;

    generate
        if (SHORT_W > 0) begin : gen_fast_mode
            assign fast_hit = (fsel_i == FAST_CODE);
        end else begin : gen_no_fast_mode
            assign fast_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        half_w = period_i >> 1;
        if (half_w == '0) begin
            half_w = CNT_W'(1);
        end
    end

    always_comb begin
        if (fast_hit) begin
            src = SRC_SHORT;
        end else if (valid_i && (period_i < THR_V)) begin
            src = SRC_HALF;
        end else begin
            src = SRC_LONG;
        end
    end

    always_comb begin
        unique case (src)
            SRC_SHORT: width_o = SHORT_V;
            SRC_HALF:  width_o = half_w;
            default:   width_o = LONG_V;
        endcase
    end

endmodule

// File: rtl/cal_pulse_fsm.sv
module cal_pulse_fsm
    import cal_pulse_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [CNT_W-1:0]  width_i,
    output logic              pulse_o,
    output logic              launch_o,
    output logic [PEND_W-1:0] pend_o
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    shp_state_e        state_q, state_d;
    logic [CNT_W-1:0]  rem_q;
    logic [PEND_W-1:0] pend_q;
    logic              is_idle, has_pend, launch, pend_inc, pend_dec;

    assign is_idle  = (state_q == ST_IDLE);
    assign has_pend = (pend_q != '0);
    assign launch   = is_idle && (req_i || has_pend);
    // A request is held unless it starts at once (idle with an empty queue)
    assign pend_inc = req_i && !(is_idle && !has_pend);
    assign pend_dec = is_idle && has_pend;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_LAUNCH, T_EXPIRE, T_WAIT, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) begin
                    state_d = ST_HIGH;      // T_LAUNCH
                end
            end
            ST_HIGH: begin
                if (rem_q == '0) begin
                    state_d = ST_IDLE;      // T_EXPIRE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Remaining high cycles, loaded at pulse start
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rem_q <= '0;
        end else if (launch) begin
            rem_q <= width_i - CNT_W'(1);
        end else if ((state_q == ST_HIGH) && (rem_q != '0)) begin
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    // Held-request counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= '0;
        end else if (pend_inc && !pend_dec) begin
            if (pend_q != PEND_MAX) begin
                pend_q <= pend_q + PEND_W'(1);
            end
        end else if (pend_dec && !pend_inc) begin
            pend_q <= pend_q - PEND_W'(1);
        end
    end

    // Outputs
    always_comb begin
        pulse_o  = (state_q == ST_HIGH);
        launch_o = launch;
        pend_o   = pend_q;
    end

endmodule

// File: rtl/cal_pulse_shaper.sv
module cal_pulse_shaper #(
    parameter int                LONG_W    = 368640,
    parameter int                SHORT_W   = 82,
    parameter int                FSEL_W    = 3,
    parameter logic [FSEL_W-1:0] FAST_CODE = FSEL_W'(3),
    parameter int                PEND_W    = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [FSEL_W-1:0] freq_sel_i,
    output logic              pulse_o
);

    localparam int THRESH = 2 * LONG_W;
    localparam int CNT_W  = $clog2(THRESH + 1) + 1;

    logic [CNT_W-1:0]  cur_period;
    logic              cur_valid;
    logic [CNT_W-1:0]  width;
    logic              launch;
    logic [PEND_W-1:0] pend_cnt;

    cal_interval_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .period_o (cur_period),
        .valid_o  (cur_valid)
    );

    cal_width_select #(
        .CNT_W     (CNT_W),
        .LONG_W    (LONG_W),
        .SHORT_W   (SHORT_W),
        .FSEL_W    (FSEL_W),
        .FAST_CODE (FAST_CODE)
    ) u_sel (
        .period_i (cur_period),
        .valid_i  (cur_valid),
        .fsel_i   (freq_sel_i),
        .width_o  (width)
    );

    cal_pulse_fsm #(
        .CNT_W  (CNT_W),
        .PEND_W (PEND_W)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .width_i  (width),
        .pulse_o  (pulse_o),
        .launch_o (launch),
        .pend_o   (pend_cnt)
    );

endmodule

// File: rtl/cal_pulse_shaper_chk.sv
module cal_pulse_shaper_chk #(
    parameter int                LONG_W    = 20,
    parameter int                SHORT_W   = 3,
    parameter int                FSEL_W    = 3,
    parameter logic [FSEL_W-1:0] FAST_CODE = FSEL_W'(3),
    parameter int                PEND_W    = 3,
    parameter int                CNT_W     = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic [FSEL_W-1:0] freq_sel_i,
    input logic              pulse_o,
    input logic              launch,
    input logic [PEND_W-1:0] pend_cnt
);

    localparam int MAXW = (LONG_W > SHORT_W) ? LONG_W : SHORT_W;

    logic [CNT_W-1:0]  run_q;
    logic [FSEL_W-1:0] mode_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q  <= '0;
            mode_q <= '0;
        end else begin
            run_q <= pulse_o ? (run_q + CNT_W'(1)) : '0;
            if (launch) begin
                mode_q <= freq_sel_i;
            end
        end
    end

    p_idle_in_reset_r1: assert property (@(posedge clk_i)
        !rst_ni |-> !pulse_o);

    p_rise_has_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pulse_o) |-> ($past(req_i) || ($past(pend_cnt) != '0)));

    p_width_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> (run_q < CNT_W'(MAXW)));

    p_short_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(pulse_o) && (mode_q == FAST_CODE)) |-> (run_q == CNT_W'(SHORT_W)));

    p_held_resume_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(pulse_o) && (pend_cnt != '0)) |=> pulse_o);

endmodule

bind cal_pulse_shaper cal_pulse_shaper_chk #(
    .LONG_W    (LONG_W),
    .SHORT_W   (SHORT_W),
    .FSEL_W    (FSEL_W),
    .FAST_CODE (FAST_CODE),
    .PEND_W    (PEND_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .freq_sel_i (freq_sel_i),
    .pulse_o    (pulse_o),
    .launch     (launch),
    .pend_cnt   (pend_cnt)
);

// File: tb/cal_pulse_shaper_tb_top.sv
module cal_pulse_shaper_tb_top;

    localparam int LW = 20;
    localparam int SW = 3;
    localparam int NV = 17;

    // Vector table: select code, cycles until next request, expected width
    localparam int V_FSEL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 3, 3, 3, 7, 1, 4, 4};
    localparam int V_WAIT [NV] = '{100, 60, 30, 30, 41, 40, 39, 25, 40, 60, 60, 10, 40, 60, 50, 30, 30};
    localparam int V_EXP  [NV] = '{20, 20, 20, 15, 15, 20, 20, 19, 12, 20, 3, 3, 3, 20, 20, 20, 15};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [2:0] fsel = 3'd0;
    logic       pulse;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    cal_pulse_shaper #(
        .LONG_W  (LW),
        .SHORT_W (SW),
        .PEND_W  (3)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_i      (req),
        .freq_sel_i (fsel),
        .pulse_o    (pulse)
    );

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] seg(input int s, input int len);
        logic [63:0] v = '0;
        for (int i = s; i < s + len; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req   = 1'b0;
        repeat (3) @(negedge clk);
        check(pulse == 1'b0, "R1 low in reset", pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Caller is at a negedge; nreq back-to-back requests, then nsamp samples
    task automatic burst(input int nreq, input int nsamp, output logic [63:0] tr);
        tr  = '0;
        req = 1'b1;
        for (int i = 0; i < nsamp; i++) begin
            @(negedge clk);
            tr[i] = pulse;
            if (i == nreq - 1) req = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] tr;
        int hi;
        logic first;

        do_reset();
        // R1: idle with no requests
        hi = 0;
        repeat (10) begin
            @(negedge clk);
            if (pulse) hi++;
        end
        check(hi == 0, "R1 idle output", hi, 0);

        // Table walk (R2, R3, R4, R5, R8)
        for (int v = 0; v < NV; v++) begin
            fsel = V_FSEL[v][2:0];
            req  = 1'b1;
            hi   = 0;
            first = 1'b0;
            for (int k = 0; k < V_WAIT[v]; k++) begin
                @(negedge clk);
                if (k == 0) begin
                    req = 1'b0;
                    first = pulse;
                end
                if (pulse) hi++;
            end
            check(hi == V_EXP[v], $sformatf("R2 R3 R4 R5 width vector %0d", v), hi, V_EXP[v]);
            check(first == 1'b1, $sformatf("R8 rise latency vector %0d", v), first, 1);
        end

        // R6 + R4 clamp: two back-to-back requests, normal mode
        do_reset();
        fsel = 3'd0;
        burst(2, 40, tr);
        check(tr == (seg(0, 20) | seg(21, 1)), "R6 R4 held pulse min width", tr, seg(0, 20) | seg(21, 1));

        // R5 + R6 + R9: short mode, two requests
        do_reset();
        fsel = 3'd3;
        burst(2, 20, tr);
        check(tr == (seg(0, 3) | seg(4, 3)), "R5 R9 short pair", tr, seg(0, 3) | seg(4, 3));

        // R6: three held in short mode
        do_reset();
        fsel = 3'd3;
        burst(3, 24, tr);
        check(tr == (seg(0, 3) | seg(4, 3) | seg(8, 3)), "R6 three requests", tr,
              seg(0, 3) | seg(4, 3) | seg(8, 3));

        // R7: select change mid-pulse has no effect
        do_reset();
        fsel = 3'd0;
        req  = 1'b1;
        hi   = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k == 0) req = 1'b0;
            if (k == 5) fsel = 3'd3;
            if (pulse) hi++;
        end
        check(hi == LW, "R7 width latched", hi, LW);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule